// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller with Offset-Match Release

This block collects a set of interrupt inputs and turns them into a single request line for a small processor core. Each input can be set to be sensitive to a level or to an edge, and to an active polarity. Each input also has a three-bit priority, where zero switches the input off. Edge-sensitive inputs are remembered in a pending flag. The block picks the highest-priority active input and raises the request line. It also reports the winner's priority and a 32-bit handler address, which joins a software-written table base with a per-source offset.

When the core acknowledges, the block freezes the winning source and its level. The handler address then holds still until software retires the request. To retire it, software writes that source's 9-bit offset into a clear register. A matching write releases the freeze and drops the pending flag of an edge source. The next-highest active source is then offered at once. A write that does not match is discarded. A level source is offered again immediately for as long as its input stays active.

Top module: `irqv_top`

## Requirements
- R1: After reset, cpuReq and cpuLevel are 0, cpuVector is 0, the base register reads 0 and every source configuration reads 0, which leaves every source disabled.
- R2: cpuVector is {base[31:9], offset}. The offset is the source index times 16: index in bits [8:4] and zero in bits [3:0]. Bits [31:9] of a base write are kept and bits [8:0] read back as 0. With no request and nothing frozen, the offset is 0.
- R3: cpuReq is high when any source with non-zero priority is active. The winner is the source with the highest priority. Equal priorities go to the lower index. cpuLevel shows the winner's priority. A source with priority 0 never requests.
- R4: When cpuAck is high at a clock edge with cpuReq high and nothing frozen, the current winner and its level are frozen. cpuVector and cpuLevel then stay unchanged, and cpuReq stays high, even if a higher-priority source arrives.
- R5: A write to the clear register (address 2) whose bits [8:0] equal the frozen offset releases the freeze at that edge. From the next cycle the highest-priority source still active is presented.
- R6: A clear-register write does nothing if its offset differs from the frozen one, or if nothing is frozen. The frozen state, the outputs and all pending flags stay as they were.
- R7: An edge source sets its pending flag on its selected edge and keeps it after the input returns. A matching clear drops the flag. Holding the input steady afterwards does not raise it again; only a new edge does.
- R8: A level source requests exactly while its input is at its active level. After a matching clear it is presented again at once if the input is still active.
- R9: Polarity bit 1 selects rising edges or active-high levels. Polarity bit 0 selects falling edges or active-low levels.
- R10: Register map, with reads combinational in the same cycle:
  - Address 0 is the base register, read/write.
  - Address 1 returns the current cpuVector and is read-only.
  - Address 2 is the clear register, which is write-only and reads 0.
  - Address 16+n is the configuration of source n: [2:0] priority, [4] mode (1 = edge), [5] polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| srcIn | input | 16 | Raw interrupt inputs, synchronised inside |
| regAddr | input | 6 | Register word address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| cpuReq | output | 1 | Interrupt request to the core |
| cpuLevel | output | 3 | Priority of the request being presented |
| cpuAck | input | 1 | Acknowledge from the core; freezes the request |
| cpuVector | output | 32 | Handler address: base joined with source offset |

## Verification
The assertions check every cycle that a frozen request keeps its vector and level until a matching clear. They also check that a matching clear always releases the freeze, that a mismatched clear leaves it in place, that an acknowledge of a live request freezes it, and that the level and offset agree with whether a request is up. The bench's scenarios cover what depends on the source inputs. These are the arbitration order across priorities and ties, the difference between level and edge sources after a clear, polarity selection, and which source takes over once a freeze is released.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned VEC_W      = 32;
  localparam int unsigned OFF_W      = 9;
  localparam int unsigned OFF_SHIFT  = 4;
  localparam int unsigned SRC_IDX_W  = 5;
  localparam int unsigned EDGE_BIT   = 4;
  localparam int unsigned POL_BIT    = 5;
  localparam int unsigned ADDR_BASE  = 0;
  localparam int unsigned ADDR_VEC   = 1;
  localparam int unsigned ADDR_CLR   = 2;
  localparam int unsigned CFG_BASE   = 16;

  typedef struct packed {
    logic                 rdBase;
    logic                 rdVec;
    logic                 cfgHit;
    logic [SRC_IDX_W-1:0] cfgSel;
    logic                 baseWr;
    logic                 cfgWr;
    logic                 pendClr;
    logic [SRC_IDX_W-1:0] clrSel;
    logic                 latchValid;
    logic [SRC_IDX_W-1:0] latchSrc;
  } irqvStrobe_t;
endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned PRIO_W  = 3
) (
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic                      winValid,
  output logic [SRC_IDX_W-1:0]      winIdx,
  output logic [PRIO_W-1:0]         winLevel
);
  logic [PRIO_W-1:0]    bestLvl;
  logic [SRC_IDX_W-1:0] bestIdx;

  // Walk from the top index down so that ties settle on the lower index.
  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (prioFlat[i*PRIO_W +: PRIO_W] != '0 &&
          prioFlat[i*PRIO_W +: PRIO_W] >= bestLvl) begin
        bestLvl = prioFlat[i*PRIO_W +: PRIO_W];
        bestIdx = SRC_IDX_W'(i);
      end
    end
  end

  assign winValid = (bestLvl != '0);
  assign winIdx   = bestIdx;
  assign winLevel = bestLvl;
endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 16,
  parameter int unsigned PRIO_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    srcIn,
  input  irqvStrobe_t           stb,
  input  logic [VEC_W-1:OFF_W]  baseWdata,
  input  logic [PRIO_W-1:0]     cfgPrioIn,
  input  logic                  cfgEdgeIn,
  input  logic                  cfgPolIn,
  output logic                  winValid,
  output logic [SRC_IDX_W-1:0]  winIdx,
  output logic [PRIO_W-1:0]     winLevel,
  output logic [VEC_W-1:0]      cpuVector,
  output logic [VEC_W-1:0]      regRdata
);
  localparam int unsigned BASE_W = VEC_W - OFF_W;

  logic [NUM_SRC-1:0]        syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0]        srcNow, srcPrev;
  logic [NUM_SRC-1:0]        cfgEdge, cfgPol, pending, edgeSeen, reqRaw;
  logic [PRIO_W-1:0]         cfgPrio [NUM_SRC];
  logic [NUM_SRC*PRIO_W-1:0] eligFlat;
  logic [BASE_W-1:0]         baseReg;
  logic [SRC_IDX_W-1:0]      offSel;
  logic [OFF_W-1:0]          offset;

  // Input synchroniser chain plus one more stage for edge detection.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      srcPrev <= '0;
    end else begin
      syncQ[0] <= srcIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      srcPrev <= syncQ[SYNC_STAGES-1];
    end
  end
  assign srcNow = syncQ[SYNC_STAGES-1];

  // Configuration and base registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baseReg <= '0;
      cfgEdge <= '0;
      cfgPol  <= '0;
      for (int i = 0; i < NUM_SRC; i++) cfgPrio[i] <= '0;
    end else begin
      if (stb.baseWr) baseReg <= baseWdata;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (stb.cfgWr && stb.cfgSel == SRC_IDX_W'(i)) begin
          cfgPrio[i] <= cfgPrioIn;
          cfgEdge[i] <= cfgEdgeIn;
          cfgPol[i]  <= cfgPolIn;
        end
      end
    end
  end

  // Per-source activity: level follows input, edge uses the pending flag.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic activeLvl;
    assign activeLvl   = cfgPol[i] ? srcNow[i] : ~srcNow[i];
    assign edgeSeen[i] = cfgPol[i] ? (srcNow[i] & ~srcPrev[i])
                                   : (~srcNow[i] & srcPrev[i]);
    assign reqRaw[i]   = cfgEdge[i] ? pending[i] : activeLvl;
    assign eligFlat[i*PRIO_W +: PRIO_W] = reqRaw[i] ? cfgPrio[i] : '0;
  end

  // A fresh edge wins over a clear landing in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (cfgEdge[i] && edgeSeen[i])
          pending[i] <= 1'b1;
        else if (stb.pendClr && stb.clrSel == SRC_IDX_W'(i))
          pending[i] <= 1'b0;
      end
    end
  end

  irqv_arbiter #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
  ) u_arb (
    .prioFlat (eligFlat),
    .winValid (winValid),
    .winIdx   (winIdx),
    .winLevel (winLevel)
  );

  // Handler address: frozen source if any, else live winner, else zero.
  always_comb begin
    if (stb.latchValid)  offSel = stb.latchSrc;
    else if (winValid)   offSel = winIdx;
    else                 offSel = '0;
  end
  assign offset    = OFF_W'(offSel) << OFF_SHIFT;
  assign cpuVector = {baseReg, offset};

  // Register read mux.
  always_comb begin
    regRdata = '0;
    if (stb.rdBase) begin
      regRdata = {baseReg, {OFF_W{1'b0}}};
    end else if (stb.rdVec) begin
      regRdata = cpuVector;
    end else if (stb.cfgHit) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (stb.cfgSel == SRC_IDX_W'(i)) begin
          regRdata[PRIO_W-1:0] = cfgPrio[i];
          regRdata[EDGE_BIT]   = cfgEdge[i];
          regRdata[POL_BIT]    = cfgPol[i];
        end
      end
    end
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [OFF_W-1:0]     clrWdata,
  input  logic                 cpuAck,
  input  logic                 winValid,
  input  logic [SRC_IDX_W-1:0] winIdx,
  input  logic [PRIO_W-1:0]    winLevel,
  output irqvStrobe_t          stb,
  output logic                 cpuReq,
  output logic [PRIO_W-1:0]    cpuLevel
);
  logic                 latchValid;
  logic [SRC_IDX_W-1:0] latchSrc;
  logic [PRIO_W-1:0]    latchLevel;
  logic [ADDR_W:0]      relAddr;
  logic                 cfgHit, clrWr, clrHit;
  logic [OFF_W-1:0]     latchedOff;

  assign relAddr    = {1'b0, regAddr} - (ADDR_W+1)'(CFG_BASE);
  assign cfgHit     = !relAddr[ADDR_W] && (relAddr < (ADDR_W+1)'(NUM_SRC));
  assign clrWr      = regWe && (regAddr == ADDR_W'(ADDR_CLR));
  assign latchedOff = OFF_W'(latchSrc) << OFF_SHIFT;
  assign clrHit     = clrWr && latchValid && (clrWdata == latchedOff);

  // Freeze on acknowledge, release on a matching clear write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latchValid <= 1'b0;
      latchSrc   <= '0;
      latchLevel <= '0;
    end else if (clrHit) begin
      latchValid <= 1'b0;
    end else if (!latchValid && cpuAck && winValid) begin
      latchValid <= 1'b1;
      latchSrc   <= winIdx;
      latchLevel <= winLevel;
    end
  end

  always_comb begin
    stb            = '0;
    stb.rdBase     = (regAddr == ADDR_W'(ADDR_BASE));
    stb.rdVec      = (regAddr == ADDR_W'(ADDR_VEC));
    stb.cfgHit     = cfgHit;
    stb.cfgSel     = relAddr[SRC_IDX_W-1:0];
    stb.baseWr     = regWe && (regAddr == ADDR_W'(ADDR_BASE));
    stb.cfgWr      = regWe && cfgHit;
    stb.pendClr    = clrHit;
    stb.clrSel     = latchSrc;
    stb.latchValid = latchValid;
    stb.latchSrc   = latchSrc;
  end

  assign cpuReq   = latchValid || winValid;
  assign cpuLevel = latchValid ? latchLevel : winLevel;
endmodule

// File: rtl/irqv_top.sv
module irqv_top
  import irqv_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 16,
  parameter int unsigned PRIO_W      = 3,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [VEC_W-1:0]   regWdata,
  output logic [VEC_W-1:0]   regRdata,
  output logic               cpuReq,
  output logic [PRIO_W-1:0]  cpuLevel,
  input  logic               cpuAck,
  output logic [VEC_W-1:0]   cpuVector
);
  irqvStrobe_t          stb;
  logic                 winValid;
  logic [SRC_IDX_W-1:0] winIdx;
  logic [PRIO_W-1:0]    winLevel;

  irqv_ctrl #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .clrWdata (regWdata[OFF_W-1:0]),
    .cpuAck   (cpuAck),
    .winValid (winValid),
    .winIdx   (winIdx),
    .winLevel (winLevel),
    .stb      (stb),
    .cpuReq   (cpuReq),
    .cpuLevel (cpuLevel)
  );

  irqv_datapath #(
    .NUM_SRC     (NUM_SRC),
    .PRIO_W      (PRIO_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .srcIn     (srcIn),
    .stb       (stb),
    .baseWdata (regWdata[VEC_W-1:OFF_W]),
    .cfgPrioIn (regWdata[PRIO_W-1:0]),
    .cfgEdgeIn (regWdata[EDGE_BIT]),
    .cfgPolIn  (regWdata[POL_BIT]),
    .winValid  (winValid),
    .winIdx    (winIdx),
    .winLevel  (winLevel),
    .cpuVector (cpuVector),
    .regRdata  (regRdata)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int unsigned PRIO_W = 3,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpuReq,
  input logic [PRIO_W-1:0] cpuLevel,
  input logic              cpuAck,
  input logic [VEC_W-1:0]  cpuVector,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic              latchValid,
  input logic              clrHit,
  input logic              baseWr
);
  a_r4_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    latchValid && !clrHit && !baseWr |=>
      latchValid && cpuReq && $stable(cpuVector) && $stable(cpuLevel));

  a_r4_ack_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    cpuAck && cpuReq && !latchValid |=> latchValid);

  a_r5_clear_releases: assert property (@(posedge clk) disable iff (!rst_n)
    clrHit |=> !latchValid);

  a_r6_mismatch_kept: assert property (@(posedge clk) disable iff (!rst_n)
    regWe && regAddr == ADDR_W'(ADDR_CLR) && latchValid && !clrHit |=>
      latchValid && $stable(cpuVector));

  a_r3_level_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    cpuReq |-> cpuLevel != '0);

  a_r2_idle_offset: assert property (@(posedge clk) disable iff (!rst_n)
    !cpuReq |-> cpuLevel == '0 && cpuVector[OFF_W-1:0] == '0);

  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpuVector[OFF_SHIFT-1:0] == '0);
endmodule

bind irqv_top irqv_checker #(
  .PRIO_W (PRIO_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpuReq     (cpuReq),
  .cpuLevel   (cpuLevel),
  .cpuAck     (cpuAck),
  .cpuVector  (cpuVector),
  .regAddr    (regAddr),
  .regWe      (regWe),
  .latchValid (stb.latchValid),
  .clrHit     (stb.pendClr),
  .baseWr     (stb.baseWr)
);

// File: tb/irqv_top_tb.sv
module irqv_top_tb;
  localparam logic [31:0] BASE_WR  = 32'h1234_5FFF;
  localparam logic [31:0] BASE_EXP = 32'h1234_5E00;

  typedef struct packed {
    logic [15:0] pins;
    logic        req;
    logic [2:0]  lvl;
    logic [4:0]  src;
  } vec_t;

  // Level mode, active high, priority(i) = i<8 ? i : 15-i.
  localparam vec_t VECS [14] = '{
    '{16'h0000, 1'b0, 3'd0, 5'd0},
    '{16'h0001, 1'b0, 3'd0, 5'd0},
    '{16'h8001, 1'b0, 3'd0, 5'd0},
    '{16'h0002, 1'b1, 3'd1, 5'd1},
    '{16'h0180, 1'b1, 3'd7, 5'd7},
    '{16'h0100, 1'b1, 3'd7, 5'd8},
    '{16'h0404, 1'b1, 3'd5, 5'd10},
    '{16'h0220, 1'b1, 3'd6, 5'd9},
    '{16'h2020, 1'b1, 3'd5, 5'd5},
    '{16'h4008, 1'b1, 3'd3, 5'd3},
    '{16'h0840, 1'b1, 3'd6, 5'd6},
    '{16'h0410, 1'b1, 3'd5, 5'd10},
    '{16'h0820, 1'b1, 3'd5, 5'd5},
    '{16'h1004, 1'b1, 3'd3, 5'd12}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] srcIn = '0;
  logic [5:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        cpuReq;
  logic [2:0]  cpuLevel;
  logic        cpuAck = 1'b0;
  logic [31:0] cpuVector;

  int nVec = 0;
  int nMiss = 0;

  always #10 clk = ~clk;

  irqv_top u_dut (
    .clk(clk), .rst_n(rst_n), .srcIn(srcIn), .regAddr(regAddr),
    .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .cpuReq(cpuReq), .cpuLevel(cpuLevel), .cpuAck(cpuAck),
    .cpuVector(cpuVector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nMiss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #2 d = regRdata;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ackPulse();
    @(negedge clk); cpuAck = 1'b1;
    @(negedge clk); cpuAck = 1'b0;
  endtask

  task automatic expectOut(input string tag, input logic req,
                           input logic [2:0] lvl, input logic [4:0] src);
    chk({tag, " req"}, 32'(cpuReq), 32'(req));
    chk({tag, " level"}, 32'(cpuLevel), 32'(lvl));
    chk({tag, " vector"}, cpuVector, BASE_EXP | (32'(src) << 4));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nMiss++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    waitCyc(3);
    // R1 reset state
    chk("R1 cpuReq", 32'(cpuReq), 32'd0);
    chk("R1 cpuLevel", 32'(cpuLevel), 32'd0);
    chk("R1 cpuVector", cpuVector, 32'd0);
    rst_n = 1'b1;
    waitCyc(2);
    busRead(6'd0, rd);  chk("R1 base", rd, 32'd0);
    busRead(6'd21, rd); chk("R1 cfg5", rd, 32'd0);

    // R2 R10 base register and map
    busWrite(6'd0, BASE_WR);
    busRead(6'd0, rd); chk("R2 base readback", rd, BASE_EXP);
    busRead(6'd2, rd); chk("R10 clear reads zero", rd, 32'd0);
    for (int i = 0; i < 16; i++)
      busWrite(6'(16 + i), 32'h20 | 32'((i < 8) ? i : 15 - i));
    busRead(6'd25, rd); chk("R10 cfg9", rd, 32'h26);

    // R3 arbitration table
    for (int v = 0; v < 14; v++) begin
      @(negedge clk); srcIn = VECS[v].pins;
      waitCyc(4);
      expectOut($sformatf("R3 vec%0d", v), VECS[v].req, VECS[v].lvl, VECS[v].src);
      busRead(6'd1, rd);
      chk($sformatf("R10 vecreg %0d", v), rd, cpuVector);
    end

    // R4 freeze against a higher arrival
    @(negedge clk); srcIn = 16'h0002;
    waitCyc(4);
    expectOut("R4 pre", 1'b1, 3'd1, 5'd1);
    ackPulse();
    @(negedge clk); srcIn = 16'h0202;
    waitCyc(4);
    expectOut("R4 frozen", 1'b1, 3'd1, 5'd1);
    // R6 mismatched offset
    busWrite(6'd2, 32'h090);
    expectOut("R6 mismatch", 1'b1, 3'd1, 5'd1);
    // R5 matching clear hands over to src9
    busWrite(6'd2, 32'h010);
    expectOut("R5 next", 1'b1, 3'd6, 5'd9);
    // R8 level source stays after clear
    ackPulse();
    busWrite(6'd2, 32'h090);
    expectOut("R8 still active", 1'b1, 3'd6, 5'd9);
    @(negedge clk); srcIn = 16'h0000;
    waitCyc(4);
    expectOut("R8 released", 1'b0, 3'd0, 5'd0);

    // R7 edge source, rising
    busWrite(6'd20, 32'h34);
    busRead(6'd20, rd); chk("R10 cfg4", rd, 32'h34);
    @(negedge clk); srcIn = 16'h0010;
    @(negedge clk); srcIn = 16'h0000;
    waitCyc(4);
    expectOut("R7 pulse pending", 1'b1, 3'd4, 5'd4);
    busWrite(6'd2, 32'h040);
    expectOut("R6 unfrozen clear", 1'b1, 3'd4, 5'd4);
    ackPulse();
    busWrite(6'd2, 32'h040);
    expectOut("R7 cleared", 1'b0, 3'd0, 5'd0);
    @(negedge clk); srcIn = 16'h0010;
    waitCyc(4);
    expectOut("R7 held edge", 1'b1, 3'd4, 5'd4);
    ackPulse();
    busWrite(6'd2, 32'h040);
    waitCyc(3);
    expectOut("R7 no re-raise", 1'b0, 3'd0, 5'd0);
    @(negedge clk); srcIn = 16'h0000;
    waitCyc(4);
    expectOut("R9 falling ignored", 1'b0, 3'd0, 5'd0);

    // R9 falling-edge source
    busWrite(6'd22, 32'h16);
    @(negedge clk); srcIn = 16'h0040;
    waitCyc(4);
    expectOut("R9 rise ignored", 1'b0, 3'd0, 5'd0);
    @(negedge clk); srcIn = 16'h0000;
    waitCyc(4);
    expectOut("R9 fall seen", 1'b1, 3'd6, 5'd6);
    ackPulse();
    busWrite(6'd2, 32'h060);
    expectOut("R9 fall cleared", 1'b0, 3'd0, 5'd0);

    // R9 active-low level source
    busWrite(6'd19, 32'h03);
    waitCyc(2);
    expectOut("R9 low active", 1'b1, 3'd3, 5'd3);
    @(negedge clk); srcIn = 16'h0008;
    waitCyc(4);
    expectOut("R9 high idle", 1'b0, 3'd0, 5'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nMiss);
    $finish;
  end
endmodule